// File: doc/BRIEF.md
# Edge-Latched Interrupt Collector with CPU Gate

This block gathers eleven peripheral interrupt lines into one request for a processor. Each line passes through a synchronizer. A rising edge on a line, meaning a change from low to high, sets that line's bit in a pending register. A separate enable register selects which pending bits can reach the processor. The request output is a plain level. It is high while at least one bit is both pending and enabled, and it goes low in the same cycle that this stops being true.

Software uses a small 32-bit register bus to reach the two registers. The pending register sits at offset 0x0 and the enable register at offset 0x4. Writing the pending register acknowledges bits and never sets them. Requests flow in on a valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high. Each accepted read returns one beat on a valid/ready response channel. `req_ready` drops while a response waits unaccepted, so the response channel applies back-pressure to the request channel. Writes return no response.

A CPU-side gate sits next to the collector. It holds two software interrupt latches and combines them with the hardware request into a three-bit cause vector. From that vector, a three-bit per-cause enable and a global enable, it decides whether the processor takes an interrupt.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, the pending register, the enable register and the software latches are zero. `irq_o`, `take_int_o` and `rsp_valid` are low, and `req_ready` is high.
- R2: A low-to-high change on `src_i[k]` sets pending bit k. The bit is readable and visible on `irq_o` three clock edges after the change: two synchronizer stages plus the edge register. If the line stays high, it does not set the bit again after the bit has been cleared.
- R3: A write to offset 0x0 is an acknowledge. Each data bit 0..10 written as 0 clears that pending bit, and each bit written as 1 leaves it unchanged.
- R4: The enable register at offset 0x4 reads back what was written in bits 0..10. In every read, bits 11..31 are zero. Reads of any other offset return zero, and writes to any other offset change neither register.
- R5: `irq_o` is high exactly when (pending AND enable) is nonzero. It falls in the cycle after the acknowledge or enable write that makes the AND zero.
- R6: If a new edge on bit k is detected on the same clock edge that a write-0 acknowledge of bit k is accepted, bit k ends up set.
- R7: When `sw_we_i` is high on a clock edge, the software latches load `sw_wdata_i[1:0]`. They hold their value otherwise, and they are visible on `cause_o[1:0]`.
- R8: `cause_o` is {`irq_o`, sw1, sw0}, and `take_int_o` = `ie_i` AND ((`cause_o` AND `im_i`) != 0). Bit 2 of `im_i` enables the hardware line, and bits 0 and 1 enable the software latches.
- R9: An accepted read raises `rsp_valid` on the next edge with the register data. The data stays stable while `rsp_ready` is low, and `req_ready` stays low until the response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 11 | Peripheral interrupt lines, asynchronous |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data consumed |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level request, (pending AND enable) != 0 |
| sw_we_i | input | 1 | Load software interrupt latches |
| sw_wdata_i | input | 2 | New software latch values |
| im_i | input | 3 | Per-cause enable {hw, sw1, sw0} |
| ie_i | input | 1 | Global interrupt enable |
| cause_o | output | 3 | {irq_o, sw1, sw0} |
| take_int_o | output | 1 | Processor should take an interrupt |

## Verification
The bench drives a line high and holds it high through an acknowledge. A design that detects levels instead of edges would set the bit again and keep `irq_o` high. The bench also lines up an edge with a write-0 acknowledge of the same bit on the same clock. A design that lets the acknowledge win would lose the interrupt. Random acknowledge patterns mix 0s and 1s, which catches inverted acknowledge polarity. Reads of unmapped offsets, and writes to them, catch decoders that alias the registers. A stalled response exposes read data that changes or `req_ready` that stays high under back-pressure.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC     = 11;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NCAUSE   = 3;
  localparam logic [ADDR_W-1:0] OFS_PEND = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ENAB = 4'h4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][N-1:0] sync_q;
  logic [N-1:0]             prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic         ack_we_i,
  input  logic         enab_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] enab_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, enab_q, keep_mask;

  // acknowledge: zero clears, one keeps; new edges override
  assign keep_mask = ack_we_i ? wdata_i : {N{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      pend_q <= (pend_q & keep_mask) | rise_i;
      if (enab_we_i) enab_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign enab_o = enab_q;
  assign irq_o  = |(pend_q & enab_q);
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate #(
  parameter int unsigned NSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hw_irq_i,
  input  logic           sw_we_i,
  input  logic [NSW-1:0] sw_wdata_i,
  input  logic [NSW:0]   im_i,
  input  logic           ie_i,
  output logic [NSW:0]   cause_o,
  output logic           take_o
);
  logic [NSW-1:0] sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_q <= '0;
    else if (sw_we_i) sw_q <= sw_wdata_i;
  end

  assign cause_o = {hw_irq_i, sw_q};
  assign take_o  = ie_i & (|(cause_o & im_i));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_wdata_i,
  input  logic [NCAUSE-1:0] im_i,
  input  logic              ie_i,
  output logic [NCAUSE-1:0] cause_o,
  output logic              take_int_o
);
  logic [NSRC-1:0]   rise_w, pend_q, enab_q;
  logic              req_fire, ack_we, enab_we;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    unique case (req_addr)
      OFS_PEND: sel = SEL_PEND;
      OFS_ENAB: sel = SEL_ENAB;
      default:  sel = SEL_NONE;
    endcase
  end

  assign ack_we  = req_fire && req_write && (sel == SEL_PEND);
  assign enab_we = req_fire && req_write && (sel == SEL_ENAB);

  irq_edge_detect #(.N(NSRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_i(src_i), .rise_o(rise_w)
  );

  irq_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .ack_we_i(ack_we), .enab_we_i(enab_we),
    .wdata_i(req_wdata[NSRC-1:0]),
    .pend_o(pend_q), .enab_o(enab_q), .irq_o(irq_o)
  );

  irq_cpu_gate #(.NSW(NCAUSE-1)) u_gate (
    .clk(clk), .rst_n(rst_n), .hw_irq_i(irq_o),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .im_i(im_i), .ie_i(ie_i),
    .cause_o(cause_o), .take_o(take_int_o)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_PEND: rd_mux[NSRC-1:0] = pend_q;
      SEL_ENAB: rd_mux[NSRC-1:0] = enab_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_sva.sv
module irq_ctrl_sva
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ie_i,
  input logic              take_int_o,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   enab_q,
  input logic [NSRC-1:0]   rise_w
);
  assert_ack_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_q) & ~pend_q)) |->
      $past(req_valid && req_ready && req_write && req_addr == OFS_PEND));

  assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~$past(pend_q))) |-> $past(|rise_w));

  assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == OFS_ENAB) |=>
      enab_q == $past(req_wdata[NSRC-1:0]));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[DATA_W-1:NSRC] == '0);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_take_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_int_o |-> ie_i);
endmodule

bind irq_ctrl_top irq_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .ie_i(ie_i), .take_int_o(take_int_o),
  .pend_q(pend_q), .enab_q(enab_q), .rise_w(rise_w)
);

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_i = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_o, take_int_o;
  logic [31:0] rsp_rdata;
  logic        sw_we_i = 1'b0, ie_i = 1'b0;
  logic [1:0]  sw_wdata_i = '0;
  logic [2:0]  im_i = '0, cause_o;

  int total = 0, bad = 0;
  logic [10:0] m_pend = '0, m_enab = '0;
  logic [1:0]  m_sw = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o), .sw_we_i(sw_we_i),
    .sw_wdata_i(sw_wdata_i), .im_i(im_i), .ie_i(ie_i),
    .cause_o(cause_o), .take_int_o(take_int_o)
  );

  function automatic logic exp_irq(input logic [10:0] p, input logic [10:0] e);
    return |(p & e);
  endfunction

  function automatic logic exp_take(input logic hw, input logic [1:0] sw,
                                    input logic [2:0] im, input logic ie);
    return ie & (|({hw, sw} & im));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic settle_src(input logic [10:0] v);
    @(negedge clk);
    m_pend = m_pend | (v & ~src_i);
    src_i = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic check_all(input string tag);
    bus_read(4'h0, rd); check({tag, " R2 R3 pending"}, rd, {21'b0, m_pend});
    bus_read(4'h4, rd); check({tag, " R4 enable"}, rd, {21'b0, m_enab});
    @(negedge clk);
    check({tag, " R5 irq"}, {31'b0, irq_o}, {31'b0, exp_irq(m_pend, m_enab)});
    check({tag, " R8 take"}, {31'b0, take_int_o},
          {31'b0, exp_take(exp_irq(m_pend, m_enab), m_sw, im_i, ie_i)});
    check({tag, " R8 cause"}, {29'b0, cause_o}, {29'b0, exp_irq(m_pend, m_enab), m_sw});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, sampled while reset is still held
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1 req_ready", {31'b0, req_ready}, 1);
    check("R1 take", {31'b0, take_int_o}, 0);
    rst_n = 1'b1;
    check_all("R1");

    // R2 exact latency: visible after third edge, not after second
    m_enab = 11'h001; bus_write(4'h4, 32'h1);
    @(negedge clk); src_i[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 latency early", {31'b0, irq_o}, 0);
    @(posedge clk); @(negedge clk);
    check("R2 latency on time", {31'b0, irq_o}, 1);
    m_pend[0] = 1'b1;
    // held-high line does not re-set after acknowledge
    m_pend[0] = 1'b0; bus_write(4'h0, 32'hFFFF_FFFE);
    repeat (4) @(posedge clk);
    check_all("R2 held high");

    // R6 edge and acknowledge on the same edge: edge wins
    m_enab = 11'h002; bus_write(4'h4, 32'h2);
    @(negedge clk); src_i[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    bus_write(4'h0, 32'h0000_0000);
    m_pend = 11'h002;
    check_all("R6 race");

    // R4 unmapped offsets
    bus_read(4'h8, rd); check("R4 unmapped read", rd, 0);
    bus_write(4'h8, 32'h0);
    bus_write(4'hC, 32'h0);
    check_all("R4 unmapped write");

    // R9 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    check("R9 rsp valid", {31'b0, rsp_valid}, 1);
    check("R9 ready low", {31'b0, req_ready}, 0);
    repeat (3) @(posedge clk); @(negedge clk);
    check("R9 held data", rsp_rdata, rd);
    check("R9 still valid", {31'b0, rsp_valid}, 1);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 released", {31'b0, req_ready}, 1);

    // R7 R8 software latches and gate
    @(negedge clk); sw_we_i = 1'b1; sw_wdata_i = 2'b10;
    @(negedge clk); sw_we_i = 1'b0; sw_wdata_i = 2'b01; m_sw = 2'b10;
    im_i = 3'b010; ie_i = 1'b1;
    check_all("R7 sw latch");
    ie_i = 1'b0; check_all("R8 ie off");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      settle_src(11'($urandom));
      case ($urandom % 3)
        0: begin
          logic [31:0] d = $urandom;
          m_pend = m_pend & d[10:0];
          bus_write(4'h0, d);
        end
        1: begin
          logic [31:0] d = $urandom;
          m_enab = d[10:0];
          bus_write(4'h4, d);
        end
        default: begin
          @(negedge clk); sw_we_i = 1'b1; sw_wdata_i = 2'($urandom);
          m_sw = sw_wdata_i;
          @(negedge clk); sw_we_i = 1'b0;
        end
      endcase
      im_i = 3'($urandom); ie_i = 1'($urandom);
      check_all("rand R3 R5 R7");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule